// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three clock sources drives the system clock: an internal RC oscillator, an external oscillator, or a PLL. It holds the software requests to turn each source on or off, the requested source selection, the PLL input and factor settings, a failure-detection enable and an interrupt enable. From these it drives the enable lines of the oscillators and the PLL, and a two-bit select code for a glitch-free clock mux that lies outside the block.

A selection only takes effect once the target source is enabled and reports ready (or locked). Until then the request stays pending and completes by itself. The block refuses to turn off a source that currently feeds the system clock. It falls back to the internal oscillator when an external-clock failure is detected while that clock is in use, and when a low-power stop request arrives. The ready, lock and failure inputs come from other clock domains, so they pass through synchronizers before any decision uses them. All logic runs on one control clock with a synchronous active-high reset.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset the internal oscillator is enabled and selected (`src_sel` = `pend_sel` = 00). The external oscillator and PLL are disabled. The failure-detect enable, interrupt enable, failure flag and `irq` are all 0, and `pll_fact` is 0.
- R2: The active source changes to the pending source only in a cycle in which the pending source is both enabled and shows ready in its synchronized status. Otherwise the request stays pending and completes without further writes once the source becomes ready.
- R3: Source codes are 00 = internal, 01 = external, 10 = PLL. A select write stores the code in `pend_sel`. A select write with code 11 is ignored, and `src_sel` never shows 11.
- R4: A write turning the external oscillator off is ignored while the active source is external (01), or while it is PLL (10) with `pll_fact[0]` = 1, meaning the PLL is fed from the external oscillator.
- R5: A write turning the PLL off is ignored while the PLL is the active source. A write turning the internal oscillator off is ignored while the internal oscillator is the active source. Either write is accepted when that source is not in use.
- R6: Any write to the external oscillator control clears the failure-detect enable, whether or not the write itself is accepted.
- R7: Writes to `pll_fact` (bit 0 selects the PLL input: 0 internal, 1 external; the upper bits hold the factors) are ignored while the PLL is enabled.
- R8: When failure detection is enabled and the synchronized failure input is high while the external clock is in use (directly or through the PLL), the active and pending sources are forced to 00, the internal oscillator is forced on, and the failure flag is set.
- R9: The failure flag is sticky until `fail_clr` is pulsed. `irq` follows the failure flag ANDed with the interrupt enable, one cycle later.
- R10: While `lp_req` is high, the external oscillator and PLL are held off, and both active and pending sources are held at 00. Enable writes to those two sources are ignored during that time. After release the internal oscillator stays selected.
- R11: The ready, lock and failure inputs pass through two flops before they are used. The status outputs `int_rdy`, `ext_rdy` and `pll_rdy` are the synchronized values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| int_wr | input | 1 | Write strobe for internal oscillator enable |
| int_wdata | input | 1 | Requested internal oscillator state |
| ext_wr | input | 1 | Write strobe for external oscillator enable |
| ext_wdata | input | 1 | Requested external oscillator state |
| pll_wr | input | 1 | Write strobe for PLL enable |
| pll_wdata | input | 1 | Requested PLL state |
| fd_wr | input | 1 | Write strobe for failure-detect enable |
| fd_wdata | input | 1 | Failure-detect enable value |
| fact_wr | input | 1 | Write strobe for PLL input/factor field |
| fact_wdata | input | FACT_W | PLL input (bit 0) and factor value |
| sel_wr | input | 1 | Write strobe for source selection |
| sel_wdata | input | 2 | Requested source code |
| ie_wr | input | 1 | Write strobe for interrupt enable |
| ie_wdata | input | 1 | Interrupt enable value |
| fail_clr | input | 1 | Clears the sticky failure flag |
| lp_req | input | 1 | Low-power stop request, level |
| int_rdy_a | input | 1 | Internal oscillator ready, asynchronous |
| ext_rdy_a | input | 1 | External oscillator ready, asynchronous |
| pll_lock_a | input | 1 | PLL lock, asynchronous |
| ext_fail_a | input | 1 | External clock failure detected, asynchronous |
| int_en | output | 1 | Internal oscillator enable |
| ext_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| fd_en | output | 1 | Failure-detect enable status |
| pll_fact | output | FACT_W | Stored PLL input and factors |
| src_sel | output | 2 | Active source code to the clock mux |
| pend_sel | output | 2 | Pending requested source code |
| int_rdy | output | 1 | Synchronized internal ready |
| ext_rdy | output | 1 | Synchronized external ready |
| pll_rdy | output | 1 | Synchronized PLL lock |
| fail_flag | output | 1 | Sticky failure flag |
| irq | output | 1 | Failure interrupt |

## Verification
The hardest state to reach is a failure fallback while the PLL is running from the external oscillator. To get there, the external source must be brought up and the PLL input pointed at it while the PLL is still off. Then the PLL is enabled and selected, and the bench waits out both modelled start-up delays before raising the failure line. The bench's oscillator model applies start-up and shut-down delays to the ready and lock lines, so pending requests are seen first waiting and then completing without further writes. Refused disables are checked both while a source is in use directly and while it is in use through the PLL.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam logic [1:0] SRC_INT = 2'b00;
  localparam logic [1:0] SRC_EXT = 2'b01;
  localparam logic [1:0] SRC_PLL = 2'b10;
  localparam logic [1:0] SRC_BAD = 2'b11;

  // lanes of the input synchronizer
  localparam int LANE_INT  = 0;
  localparam int LANE_EXT  = 1;
  localparam int LANE_PLL  = 2;
  localparam int LANE_FAIL = 3;
  localparam int NUM_LANES = 4;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = STAGES - 1;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], d[g]};
      end
      assign q[g] = chain[TOP];
    end
  endgenerate
endmodule

// File: rtl/clksw_osc_ctrl.sv
module clksw_osc_ctrl
  import clksw_pkg::*;
#(
  parameter int              FACT_W     = 16,
  parameter logic [FACT_W-1:0] FACT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_wr,
  input  logic              int_wdata,
  input  logic              ext_wr,
  input  logic              ext_wdata,
  input  logic              pll_wr,
  input  logic              pll_wdata,
  input  logic              fd_wr,
  input  logic              fd_wdata,
  input  logic              fact_wr,
  input  logic [FACT_W-1:0] fact_wdata,
  input  logic [1:0]        src,
  input  logic              lp_req,
  input  logic              force_int,
  output logic              int_on,
  output logic              ext_on,
  output logic              pll_on,
  output logic              fd_on,
  output logic [FACT_W-1:0] fact,
  output logic              ext_in_use
);
  logic int_in_use, pll_in_use;

  always_comb begin
    int_in_use = (src == SRC_INT);
    pll_in_use = (src == SRC_PLL);
    ext_in_use = (src == SRC_EXT) || (pll_in_use && fact[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_on <= 1'b1;
      ext_on <= 1'b0;
      pll_on <= 1'b0;
      fd_on  <= 1'b0;
      fact   <= FACT_RESET;
    end else begin
      // internal oscillator: refuse turning off the active source
      if (int_wr && (int_wdata || !int_in_use)) int_on <= int_wdata;
      if (force_int || lp_req) int_on <= 1'b1;

      // external oscillator: any write drops failure detection
      if (ext_wr) begin
        fd_on <= 1'b0;
        if (ext_wdata || !ext_in_use) ext_on <= ext_wdata;
      end else if (fd_wr) begin
        fd_on <= fd_wdata;
      end

      if (pll_wr && (pll_wdata || !pll_in_use)) pll_on <= pll_wdata;

      // factor field frozen while the PLL runs
      if (fact_wr && !pll_on) fact <= fact_wdata;

      if (lp_req) begin
        ext_on <= 1'b0;
        pll_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clksw_sel_fsm.sv
module clksw_sel_fsm
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       int_ok,
  input  logic       ext_ok,
  input  logic       pll_ok,
  input  logic       fail_det,
  input  logic       lp_req,
  input  logic       fail_clr,
  input  logic       ie_wr,
  input  logic       ie_wdata,
  output logic [1:0] src,
  output logic [1:0] pend,
  output logic       fail_flag,
  output logic       irq
);
  typedef enum logic [1:0] {ST_STEADY, ST_WAIT, ST_FORCED} state_e;
  state_e state;
  logic   ie_on;
  logic   tgt_ok;

  always_comb begin
    unique case (pend)
      SRC_INT: tgt_ok = int_ok;
      SRC_EXT: tgt_ok = ext_ok;
      SRC_PLL: tgt_ok = pll_ok;
      default: tgt_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_STEADY;
      src       <= SRC_INT;
      pend      <= SRC_INT;
      fail_flag <= 1'b0;
      ie_on     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (sel_wr && sel_wdata != SRC_BAD) pend <= sel_wdata;

      unique case (state)
        ST_STEADY: if (pend != src) state <= ST_WAIT;
        ST_WAIT: begin
          if (pend == src) state <= ST_STEADY;
          else if (tgt_ok) begin
            src   <= pend;
            state <= ST_STEADY;
          end
        end
        ST_FORCED: if (!lp_req) state <= ST_STEADY;
        default: state <= ST_STEADY;
      endcase

      if (fail_det || lp_req) begin
        src   <= SRC_INT;
        pend  <= SRC_INT;
        state <= ST_FORCED;
      end

      if (fail_clr) fail_flag <= 1'b0;
      if (fail_det) fail_flag <= 1'b1;
      if (ie_wr) ie_on <= ie_wdata;
      irq <= fail_flag && ie_on;
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int FACT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_wr,
  input  logic              int_wdata,
  input  logic              ext_wr,
  input  logic              ext_wdata,
  input  logic              pll_wr,
  input  logic              pll_wdata,
  input  logic              fd_wr,
  input  logic              fd_wdata,
  input  logic              fact_wr,
  input  logic [FACT_W-1:0] fact_wdata,
  input  logic              sel_wr,
  input  logic [1:0]        sel_wdata,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  input  logic              fail_clr,
  input  logic              lp_req,
  input  logic              int_rdy_a,
  input  logic              ext_rdy_a,
  input  logic              pll_lock_a,
  input  logic              ext_fail_a,
  output logic              int_en,
  output logic              ext_en,
  output logic              pll_en,
  output logic              fd_en,
  output logic [FACT_W-1:0] pll_fact,
  output logic [1:0]        src_sel,
  output logic [1:0]        pend_sel,
  output logic              int_rdy,
  output logic              ext_rdy,
  output logic              pll_rdy,
  output logic              fail_flag,
  output logic              irq
);
  logic [NUM_LANES-1:0] raw_in, synced;
  logic ext_in_use, fail_det;

  always_comb begin
    raw_in            = '0;
    raw_in[LANE_INT]  = int_rdy_a;
    raw_in[LANE_EXT]  = ext_rdy_a;
    raw_in[LANE_PLL]  = pll_lock_a;
    raw_in[LANE_FAIL] = ext_fail_a;
  end

  clksw_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  assign int_rdy  = synced[LANE_INT];
  assign ext_rdy  = synced[LANE_EXT];
  assign pll_rdy  = synced[LANE_PLL];
  assign fail_det = fd_en && synced[LANE_FAIL] && ext_in_use;

  clksw_osc_ctrl #(.FACT_W(FACT_W)) i_osc (
    .clk(clk), .rst(rst),
    .int_wr(int_wr), .int_wdata(int_wdata),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .pll_wr(pll_wr), .pll_wdata(pll_wdata),
    .fd_wr(fd_wr), .fd_wdata(fd_wdata),
    .fact_wr(fact_wr), .fact_wdata(fact_wdata),
    .src(src_sel), .lp_req(lp_req), .force_int(fail_det),
    .int_on(int_en), .ext_on(ext_en), .pll_on(pll_en),
    .fd_on(fd_en), .fact(pll_fact), .ext_in_use(ext_in_use)
  );

  clksw_sel_fsm i_sel (
    .clk(clk), .rst(rst),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .int_ok(int_en && int_rdy), .ext_ok(ext_en && ext_rdy),
    .pll_ok(pll_en && pll_rdy),
    .fail_det(fail_det), .lp_req(lp_req), .fail_clr(fail_clr),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .src(src_sel), .pend(pend_sel), .fail_flag(fail_flag), .irq(irq)
  );
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk #(
  parameter int FACT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lp_req,
  input logic              ext_en,
  input logic              pll_en,
  input logic              ext_rdy,
  input logic              pll_rdy,
  input logic [FACT_W-1:0] pll_fact,
  input logic [1:0]        src_sel,
  input logic              fail_flag,
  input logic              irq
);
  assert_src_legal_R3: assert property (@(posedge clk) disable iff (rst)
    src_sel != 2'b11);

  assert_ext_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (src_sel != 2'b01 && !(ext_rdy && ext_en)) |=> src_sel != 2'b01);

  assert_pll_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (src_sel != 2'b10 && !(pll_rdy && pll_en)) |=> src_sel != 2'b10);

  assert_ext_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (ext_en && !lp_req && (src_sel == 2'b01 || (src_sel == 2'b10 && pll_fact[0])))
      |=> ext_en);

  assert_pll_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (pll_en && !lp_req && src_sel == 2'b10) |=> pll_en);

  assert_fact_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    pll_en |=> $stable(pll_fact));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(fail_flag));

  assert_lp_forces_R10: assert property (@(posedge clk) disable iff (rst)
    lp_req |=> (src_sel == 2'b00 && !ext_en && !pll_en));
endmodule

bind clksw_ctrl clksw_ctrl_chk #(.FACT_W(FACT_W)) i_chk (
  .clk(clk), .rst(rst), .lp_req(lp_req), .ext_en(ext_en), .pll_en(pll_en),
  .ext_rdy(ext_rdy), .pll_rdy(pll_rdy), .pll_fact(pll_fact),
  .src_sel(src_sel), .fail_flag(fail_flag), .irq(irq)
);

// File: tb/test_clksw_ctrl.sv
`timescale 1ns/1ps
module test_clksw_ctrl;
  localparam int FACT_W    = 16;
  localparam int EXT_START = 8;
  localparam int EXT_STOP  = 6;
  localparam int PLL_LOCK  = 10;

  typedef enum int {S_SRC, S_PEND, S_INTEN, S_EXTEN, S_PLLEN, S_FDEN,
                    S_FACT, S_EXTRDY, S_FAIL, S_IRQ} sig_e;
  typedef struct {sig_e sig; int exp; string tag;} item_t;

  logic clk = 0;
  logic rst = 1;
  logic int_wr = 0, int_wdata = 0, ext_wr = 0, ext_wdata = 0;
  logic pll_wr = 0, pll_wdata = 0, fd_wr = 0, fd_wdata = 0;
  logic fact_wr = 0, sel_wr = 0, ie_wr = 0, ie_wdata = 0;
  logic fail_clr = 0, lp_req = 0, ext_fail_a = 0;
  logic [FACT_W-1:0] fact_wdata = '0;
  logic [1:0] sel_wdata = '0;
  logic int_rdy_a = 0, ext_rdy_a = 0, pll_lock_a = 0;
  logic int_en, ext_en, pll_en, fd_en, int_rdy, ext_rdy, pll_rdy, fail_flag, irq;
  logic [FACT_W-1:0] pll_fact;
  logic [1:0] src_sel, pend_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  item_t sb[$];

  always #5 clk = ~clk;

  clksw_ctrl #(.FACT_W(FACT_W)) i_clksw_ctrl (.*);

  // oscillator and PLL model
  int ext_cnt = 0, pll_cnt = 0, int_cnt = 0;
  always @(posedge clk) begin
    if (ext_en) begin
      ext_cnt <= (ext_cnt < 0) ? 0 : ext_cnt + 1;
      if (ext_cnt >= EXT_START) ext_rdy_a <= 1;
    end else begin
      ext_cnt <= (ext_cnt > 0) ? -1 : ext_cnt - 1;
      if (ext_cnt <= -EXT_STOP) ext_rdy_a <= 0;
    end
    pll_cnt   <= pll_en ? pll_cnt + 1 : 0;
    pll_lock_a <= pll_en && (pll_cnt >= PLL_LOCK);
    int_cnt   <= int_en ? int_cnt + 1 : 0;
    int_rdy_a <= int_en && (int_cnt >= 2);
  end

  function automatic int read_sig(sig_e s);
    case (s)
      S_SRC:    return int'(src_sel);
      S_PEND:   return int'(pend_sel);
      S_INTEN:  return int'(int_en);
      S_EXTEN:  return int'(ext_en);
      S_PLLEN:  return int'(pll_en);
      S_FDEN:   return int'(fd_en);
      S_FACT:   return int'(pll_fact);
      S_EXTRDY: return int'(ext_rdy);
      S_FAIL:   return int'(fail_flag);
      default:  return int'(irq);
    endcase
  endfunction

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        act = read_sig(it.sig);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: %s actual=%0d expected=%0d", it.tag, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(sig_e s, int v, string tag);
    sb.push_back('{s, v, tag});
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ext(logic v);
    ext_wr = 1; ext_wdata = v; cyc(1); ext_wr = 0;
  endtask
  task automatic wr_pll(logic v);
    pll_wr = 1; pll_wdata = v; cyc(1); pll_wr = 0;
  endtask
  task automatic wr_int(logic v);
    int_wr = 1; int_wdata = v; cyc(1); int_wr = 0;
  endtask
  task automatic wr_fd(logic v);
    fd_wr = 1; fd_wdata = v; cyc(1); fd_wr = 0;
  endtask
  task automatic wr_ie(logic v);
    ie_wr = 1; ie_wdata = v; cyc(1); ie_wr = 0;
  endtask
  task automatic wr_sel(logic [1:0] v);
    sel_wr = 1; sel_wdata = v; cyc(1); sel_wr = 0;
  endtask
  task automatic wr_fact(logic [FACT_W-1:0] v);
    fact_wr = 1; fact_wdata = v; cyc(1); fact_wr = 0;
  endtask

  task automatic finish_run();
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 0;
    cyc(1);
    // R1 reset state
    expect_v(S_SRC, 0, "R1"); expect_v(S_PEND, 0, "R1");
    expect_v(S_INTEN, 1, "R1"); expect_v(S_EXTEN, 0, "R1");
    expect_v(S_PLLEN, 0, "R1"); expect_v(S_FDEN, 0, "R1");
    expect_v(S_FAIL, 0, "R1"); expect_v(S_IRQ, 0, "R1");
    expect_v(S_FACT, 0, "R1");
    cyc(6);
    // R5 internal off refused while in use
    wr_int(0);
    expect_v(S_INTEN, 1, "R5");
    // R2/R3 pending request with external off
    wr_sel(2'b01);
    expect_v(S_PEND, 1, "R3"); expect_v(S_SRC, 0, "R2");
    cyc(20);
    expect_v(S_SRC, 0, "R2");
    wr_ext(1);
    cyc(5);
    expect_v(S_EXTRDY, 0, "R11"); expect_v(S_SRC, 0, "R2");
    cyc(15);
    expect_v(S_EXTRDY, 1, "R11"); expect_v(S_SRC, 1, "R2");
    // R6 ext write clears failure detect
    wr_fd(1);
    expect_v(S_FDEN, 1, "R6");
    wr_ext(1);
    expect_v(S_FDEN, 0, "R6");
    // R4 direct use
    wr_ext(0);
    expect_v(S_EXTEN, 1, "R4");
    // R3 invalid code ignored
    wr_sel(2'b11);
    expect_v(S_PEND, 1, "R3");
    // R7 factors
    wr_fact(16'h0101);
    expect_v(S_FACT, 16'h0101, "R7");
    wr_pll(1);
    wr_fact(16'h0F00);
    expect_v(S_FACT, 16'h0101, "R7");
    // switch to PLL
    wr_sel(2'b10);
    expect_v(S_SRC, 1, "R2");
    cyc(20);
    expect_v(S_SRC, 2, "R2");
    // R5 PLL off refused, R4 via PLL
    wr_pll(0);
    expect_v(S_PLLEN, 1, "R5");
    wr_ext(0);
    expect_v(S_EXTEN, 1, "R4");
    // R5 internal off allowed when not in use
    wr_int(0);
    expect_v(S_INTEN, 0, "R5");
    // R8 failure fallback
    wr_fd(1);
    wr_ie(1);
    ext_fail_a = 1;
    cyc(5);
    ext_fail_a = 0;
    expect_v(S_SRC, 0, "R8"); expect_v(S_PEND, 0, "R8");
    expect_v(S_FAIL, 1, "R8"); expect_v(S_INTEN, 1, "R8");
    expect_v(S_IRQ, 1, "R9");
    cyc(4);
    expect_v(S_FAIL, 1, "R9");
    fail_clr = 1; cyc(1); fail_clr = 0;
    expect_v(S_FAIL, 0, "R9");
    cyc(1);
    expect_v(S_IRQ, 0, "R9");
    // R5 PLL off now allowed
    wr_pll(0);
    expect_v(S_PLLEN, 0, "R5");
    // R10 low power
    wr_sel(2'b01);
    cyc(3);
    expect_v(S_SRC, 1, "R2");
    lp_req = 1;
    cyc(1);
    expect_v(S_SRC, 0, "R10"); expect_v(S_PEND, 0, "R10");
    expect_v(S_EXTEN, 0, "R10"); expect_v(S_PLLEN, 0, "R10");
    wr_ext(1);
    expect_v(S_EXTEN, 0, "R10");
    cyc(3);
    lp_req = 0;
    cyc(3);
    expect_v(S_SRC, 0, "R10");
    wr_ext(1);
    expect_v(S_EXTEN, 1, "R10");
    finish_run();
  end
endmodule